// File: doc/BRIEF.md
# Two-Level Six-Agent Bus Arbiter with Phantom Slots

This block shares one system bus among six requesters that form two groups of three. Each group runs a four-slot round-robin rotation. Slots 0 to 2 are the group's real requesters. Slot 3 is a phantom entry that stands for the entire other group. Exactly one group is active at a time. When the active rotation reaches its phantom slot, control moves to the other group. That group then picks one of its own requesters in the same decision, so the pair of three-agent arbiters acts as a single fair six-agent arbiter.

Grants are registered. A grant is held until the owner raises `done_i` in its last bus cycle. The next owner is chosen at that same clock edge, or at any edge while the bus has no owner. The outputs are six grant lines, the winner's 2-bit slot number within its group, and the active group bit.

Top module: `phantom_rr_arbiter`

## Requirements
- R1: While `rst_ni` is low, all grants are 0 and `grp_o` is 0 (group A). Both rotations are parked on the phantom slot, so the first search in each group starts at slot 0.
- R2: Inside the active group, the search starts at the slot after the last owner and moves upward, wrapping from 3 to 0. For example, if A slot 2 owned the bus and A slot 1 and any B requester are pending, the phantom (slot 3) wins first and a B requester is granted.
- R3: With all six lines requesting and `done_i` high every cycle, grants go in the order A0, A1, A2, B0, B1, B2, A0. These are `gnt_o` bits 0, 1, 2, 3, 4, 5, 0. Bit index = 3*group + slot.
- R4: The active group's phantom slot requests whenever any line of the other group requests. A phantom win flips `grp_o` and grants a real requester of the other group at the same edge. No phantom ever drives a grant line.
- R5: A group that regains the bus searches its slots from slot 0, because its remembered position is the phantom slot. A group that keeps the bus continues from its last local owner.
- R6: A new decision is taken only when no grant is held or when `done_i` is high. Otherwise `gnt_o`, `gnt_id_o` and `grp_o` stay unchanged.
- R7: If a decision finds no request in either group, all grants go to 0. `grp_o` and both rotation positions keep their values.
- R8: `gnt_o` is one-hot or all zero. When a grant is held, `gnt_id_o` is in 0..2 and the set bit is 3*`grp_o` + `gnt_id_o`.
- R9: An owner keeps its grant even if its request line falls, until it raises `done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Request lines; bits 0-2 group A slots 0-2, bits 3-5 group B slots 0-2 |
| done_i | input | 1 | Current owner finishes its bus cycle at this edge |
| gnt_o | output | 6 | Registered grant lines, same bit order as req_i |
| gnt_id_o | output | 2 | Slot number of the current owner inside its group |
| grp_o | output | 1 | Active group: 0 = A, 1 = B |

## Verification
Two things can happen at the same edge. An owner can release the bus with `done_i`, and the active rotation can land on its phantom slot, which moves control across groups. The bench provokes this by ending an ownership while only the other group requests, or while both groups request with the phantom next in line. It then checks that the grant goes straight to the correct real requester in the other group and that `grp_o` flips at that edge. Directed sequences pin the full rotation, the wrap example and idle retention. Random request and release patterns are then compared cycle by cycle against a rotation model in the bench.

// File: rtl/phantom_rr_pkg.sv
`timescale 1ns/1ps
package phantom_rr_pkg;
  localparam int unsigned GRP_N   = 2;
  localparam int unsigned REAL_N  = 3;
  localparam int unsigned SLOT_N  = REAL_N + 1;
  localparam int unsigned ID_W    = $clog2(SLOT_N);
  localparam int unsigned REQ_N   = GRP_N * REAL_N;
  localparam logic [ID_W-1:0] PHANTOM = ID_W'(REAL_N);
endpackage

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
  parameter int unsigned N = 4,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic         found_o,
  output logic [W-1:0] win_o
);
  always_comb begin
    found_o = 1'b0;
    win_o   = last_i;
    for (int unsigned k = 1; k <= N; k++) begin
      int unsigned idx;
      idx = (int'(last_i) + k) % N;
      if (!found_o && req_i[idx]) begin
        found_o = 1'b1;
        win_o   = W'(idx);
      end
    end
  end
endmodule

// File: rtl/rr_pos_reg.sv
`timescale 1ns/1ps
module rr_pos_reg #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/phantom_rr_arbiter.sv
`timescale 1ns/1ps
module phantom_rr_arbiter
  import phantom_rr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_N-1:0] req_i,
  input  logic             done_i,
  output logic [REQ_N-1:0] gnt_o,
  output logic [ID_W-1:0]  gnt_id_o,
  output logic             grp_o
);
  logic             act_q;
  logic [GRP_N-1:0] any_req;
  logic [GRP_N-1:0] found;
  logic [ID_W-1:0]  win  [GRP_N];
  logic [ID_W-1:0]  pos  [GRP_N];
  logic [GRP_N-1:0] pos_en;

  logic             decide, act_found, handoff, nxt_grp;
  logic [ID_W-1:0]  act_win, nxt_slot;
  logic [REQ_N-1:0] gnt_d;

  assign decide = !(|gnt_o) || done_i;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic [SLOT_N-1:0] slot_req;
    assign any_req[g] = |req_i[g*REAL_N +: REAL_N];
    // phantom requests only in the active group, on behalf of the other one
    assign slot_req = {(act_q == 1'(g)) && any_req[GRP_N-1-g], req_i[g*REAL_N +: REAL_N]};

    rr_pick #(.N(SLOT_N), .W(ID_W)) i_pick (
      .req_i  (slot_req),
      .last_i (pos[g]),
      .found_o(found[g]),
      .win_o  (win[g])
    );

    assign pos_en[g] = decide && act_found && ((act_q == 1'(g)) || handoff);

    rr_pos_reg #(.W(ID_W), .RST_VAL(PHANTOM)) i_pos (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (pos_en[g]),
      .d_i   (win[g]),
      .q_o   (pos[g])
    );
  end

  assign act_found = found[act_q];
  assign act_win   = win[act_q];
  assign handoff   = act_found && (act_win == PHANTOM);
  assign nxt_grp   = handoff ? ~act_q : act_q;
  assign nxt_slot  = handoff ? win[~act_q] : act_win;

  always_comb begin
    gnt_d = '0;
    if (act_found) gnt_d[int'(nxt_grp) * REAL_N + int'(nxt_slot)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      gnt_o    <= '0;
      gnt_id_o <= '0;
    end else if (decide) begin
      gnt_o <= gnt_d;
      if (act_found) begin
        act_q    <= nxt_grp;
        gnt_id_o <= nxt_slot;
      end
    end
  end

  assign grp_o = act_q;

  // R8
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R8
  gnt_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (gnt_id_o != PHANTOM && gnt_o[int'(grp_o) * REAL_N + int'(gnt_id_o)]));
  // R6
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|gnt_o) && !done_i) |=> ($stable(gnt_o) && $stable(grp_o) && $stable(gnt_id_o)));
  // R7
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|req_i) && (!(|gnt_o) || done_i)) |=> (gnt_o == '0 && $stable(grp_o)));
  // R4
  grp_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(grp_o) |-> (|gnt_o));
endmodule

// File: tb/test_phantom_rr_arbiter.sv
`timescale 1ns/1ps
module test_phantom_rr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic       done = 1'b0;
  logic [5:0] gnt;
  logic [1:0] gid;
  logic       grp;

  int checks = 0, fails = 0;
  int m_act, m_own;
  int m_pos [2];

  always #2.5 clk = ~clk;

  phantom_rr_arbiter i_phantom_rr_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .gnt_o(gnt), .gnt_id_o(gid), .grp_o(grp)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit slot_req(logic [5:0] r, int g, int s);
    if (s < 3) return r[g*3+s];
    return (g == m_act) && (|r[(1-g)*3 +: 3]);
  endfunction

  task automatic model_step(logic [5:0] r, logic d);
    int g, win;
    if (!(m_own < 0 || d)) return;
    g = m_act; win = -1;
    for (int k = 1; k <= 4; k++) begin
      int s;
      s = (m_pos[g] + k) % 4;
      if (win < 0 && slot_req(r, g, s)) win = s;
    end
    if (win < 0) begin m_own = -1; return; end
    m_pos[g] = win;
    if (win == 3) begin
      int o, w2;
      o = 1 - g; w2 = -1;
      for (int k = 1; k <= 4; k++) begin
        int s;
        s = (m_pos[o] + k) % 4;
        if (w2 < 0 && s < 3 && r[o*3+s]) w2 = s;
      end
      m_act = o; m_pos[o] = w2; m_own = o*3 + w2;
    end else begin
      m_own = g*3 + win;
    end
  endtask

  task automatic cyc(logic [5:0] r, logic d, string tag);
    @(negedge clk);
    req = r; done = d;
    @(posedge clk);
    model_step(r, d);
    #1;
    chk({tag, " gnt"}, int'(gnt), (m_own < 0) ? 0 : (1 << m_own));
    chk({tag, " grp"}, int'(grp), m_act);
    if (m_own >= 0) chk({tag, " id"}, int'(gid), m_own % 3);
  endtask

  int seq_exp [8] = '{0, 1, 2, 3, 4, 5, 0, 1};

  initial begin
    bit [31:0] seed;
    seed = $urandom(32'h5eed_0617);
    m_act = 0; m_own = -1; m_pos[0] = 3; m_pos[1] = 3;
    #12;
    // R1 reset state
    chk("R1 gnt in reset", int'(gnt), 0);
    chk("R1 grp in reset", int'(grp), 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 full rotation, A then B, back to A
    for (int i = 0; i < 8; i++) begin
      cyc(6'h3f, 1'b1, "R3");
      chk("R3 order", int'(gnt), 1 << seq_exp[i]);
    end

    // R2 wrap example: A2 owns, A1 and B pending -> phantom first -> B0
    cyc(6'b000100, 1'b1, "R2 setup");
    chk("R2 A2 owner", int'(gnt), 6'b000100);
    cyc(6'b001010, 1'b1, "R2");
    chk("R2 phantom before slot1", int'(gnt), 6'b001000);
    chk("R4 grp flips to B", int'(grp), 1);

    // R6 / R9 hold while not done, even with request dropped
    cyc(6'b110101, 1'b0, "R6");
    cyc(6'b000000, 1'b0, "R9");
    chk("R9 owner holds after req drop", int'(gnt), 6'b001000);

    // R7 idle keeps group and positions
    cyc(6'b000000, 1'b1, "R7");
    chk("R7 no grant", int'(gnt), 0);
    cyc(6'b000000, 1'b0, "R7");
    cyc(6'b000000, 1'b1, "R7");
    chk("R7 grp kept", int'(grp), 1);
    cyc(6'h3f, 1'b1, "R7");
    chk("R7 position kept -> B1", int'(gnt), 6'b010000);

    // R5 group keeps bus continues; regaining group starts at slot 0
    cyc(6'b100110, 1'b1, "R5");
    chk("R5 B continues to B2", int'(gnt), 6'b100000);
    cyc(6'b000110, 1'b1, "R5");
    chk("R5 A resumes at first pending from 0", int'(gnt), 6'b000010);
    chk("R4 grp back to A", int'(grp), 0);

    // random traffic mixed against the model
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] r;
      logic d;
      r = 6'($urandom);
      if ($urandom % 4 == 0) r = '0;
      if ($urandom % 5 == 0) r = r & 6'b111000;
      d = ($urandom % 3) == 0;
      cyc(r, d, "R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule